// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor that completes one instruction per clock. Each cycle it fetches a word from its internal instruction store, decodes it, and reads up to two registers from a 32-entry register file. It then computes a result in the ALU, optionally reads or writes its internal data store, writes one register back, and selects the next program counter. The supported set covers three-register arithmetic (add, sub, slt), immediate operations (addi, slti, andi, ori, lui), word load and store, the two equality branches and an absolute jump. A 32-bit constant is built from an upper-half load followed by an OR with the lower half.

Both stores are small word arrays. A loader fills them through plain write strobes before releasing reset. The loader accepts a write on every clock and never stalls, so these ports need no back-pressure. Two debug pins are provided. One shows the current program counter. The other returns the contents of any register that a select input names, without waiting for a clock.

Top module: `lsc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and every register becomes 0. Fetch starts at address 0 after `rst` falls.
- R2: Register 0 always reads as 0. An instruction that targets register 0 leaves it at 0.
- R3: Opcode 0 selects the three-register format: op [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0]. Funct 32 writes rs+rt to rd, funct 34 writes rs-rt to rd, and funct 42 writes 1 to rd when rs < rt as signed values, or 0 otherwise.
- R4: In the immediate format the immediate sits in [15:0] and the result goes to rt. Opcode 8 adds the sign-extended immediate to rs. Opcode 10 sets rt to 1 when rs < sign-extended immediate (signed). Opcode 12 ANDs rs with the zero-extended immediate, and opcode 13 ORs rs with it.
- R5: Opcode 15 writes {immediate, 16'h0000} to rt. Following it with opcode 13 on the same register yields any 32-bit constant.
- R6: Opcode 35 loads the data word at byte address rs + sign-extended immediate into rt. Opcode 43 stores rt to that address. The word index is address bits [n+1:2].
- R7: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. A taken branch goes to PC+4 + (sign-extended immediate << 2). A branch that is not taken goes to PC+4.
- R8: Opcode 2 jumps to {PC[31:28], instr[25:0], 2'b00}.
- R9: Any other opcode, or opcode 0 with any other funct, writes no register and no memory, and the PC advances by 4.
- R10: `dbg_pc` shows the address of the instruction being executed. `dbg_reg_data` shows the register named by `dbg_reg_sel` in the same cycle.
- R11: A high `imem_we` or `dmem_we` writes the word to the given word index at the rising edge. The core fetches or loads that word afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction store write strobe |
| imem_waddr | input | IAW | Instruction store word index |
| imem_wdata | input | 32 | Instruction word to write |
| dmem_we | input | 1 | Data store write strobe |
| dmem_waddr | input | DAW | Data store word index |
| dmem_wdata | input | 32 | Data word to write |
| dbg_reg_sel | input | 5 | Register number for the debug tap |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg_data | output | 32 | Contents of the selected register |

## Verification
The hardest conditions to reach from the ports are a backward branch that loops until a counter register reaches zero, and a store followed at once by a load of the same word. Both occur only when the right register values have been built up by earlier instructions. Directed programs set up such a loop, along with skipped instructions, writes to register 0 and illegal encodings. Seeded random programs mix every instruction class, including forward branches that use a few shared registers so that equality happens often. Every program ends in a jump to itself, so the program counter can be compared on every cycle and all registers can be read back once the core is parked.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int XLEN = 32;
  localparam int NREGS = 32;
  localparam int RAW = $clog2(NREGS);

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_ANDI  = 6'd12;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_LUI   = 6'd15;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_PASS
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SIGN, IMM_ZERO, IMM_UPPER
  } imm_kind_e;

  typedef struct packed {
    logic      legal;
    logic      reg_write;
    logic      dst_rd;
    logic      use_imm;
    imm_kind_e imm_kind;
    alu_op_e   alu_op;
    logic      mem_read;
    logic      mem_write;
    logic      br_eq;
    logic      br_ne;
    logic      jump;
  } ctrl_t;
endpackage

// File: rtl/lsc_decoder.sv
module lsc_decoder
  import lsc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    ctl.imm_kind = IMM_SIGN;
    ctl.alu_op   = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctl.dst_rd = 1'b1;
        unique case (funct)
          FN_ADD: begin ctl.legal = 1'b1; ctl.reg_write = 1'b1; ctl.alu_op = ALU_ADD; end
          FN_SUB: begin ctl.legal = 1'b1; ctl.reg_write = 1'b1; ctl.alu_op = ALU_SUB; end
          FN_SLT: begin ctl.legal = 1'b1; ctl.reg_write = 1'b1; ctl.alu_op = ALU_SLT; end
          default: ctl.dst_rd = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctl.legal = 1'b1; ctl.reg_write = 1'b1; ctl.use_imm = 1'b1;
        ctl.alu_op = ALU_ADD;
      end
      OP_SLTI: begin
        ctl.legal = 1'b1; ctl.reg_write = 1'b1; ctl.use_imm = 1'b1;
        ctl.alu_op = ALU_SLT;
      end
      OP_ANDI: begin
        ctl.legal = 1'b1; ctl.reg_write = 1'b1; ctl.use_imm = 1'b1;
        ctl.imm_kind = IMM_ZERO; ctl.alu_op = ALU_AND;
      end
      OP_ORI: begin
        ctl.legal = 1'b1; ctl.reg_write = 1'b1; ctl.use_imm = 1'b1;
        ctl.imm_kind = IMM_ZERO; ctl.alu_op = ALU_OR;
      end
      OP_LUI: begin
        ctl.legal = 1'b1; ctl.reg_write = 1'b1; ctl.use_imm = 1'b1;
        ctl.imm_kind = IMM_UPPER; ctl.alu_op = ALU_PASS;
      end
      OP_LW: begin
        ctl.legal = 1'b1; ctl.reg_write = 1'b1; ctl.use_imm = 1'b1;
        ctl.mem_read = 1'b1; ctl.alu_op = ALU_ADD;
      end
      OP_SW: begin
        ctl.legal = 1'b1; ctl.use_imm = 1'b1; ctl.mem_write = 1'b1;
        ctl.alu_op = ALU_ADD;
      end
      OP_BEQ: begin ctl.legal = 1'b1; ctl.br_eq = 1'b1; ctl.alu_op = ALU_SUB; end
      OP_BNE: begin ctl.legal = 1'b1; ctl.br_ne = 1'b1; ctl.alu_op = ALU_SUB; end
      OP_J:   begin ctl.legal = 1'b1; ctl.jump = 1'b1; end
      default: ctl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsc_alu.sv
module lsc_alu
  import lsc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_ADD:  result = a + b;
      ALU_SUB:  result = a - b;
      ALU_SLT:  result = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_AND:  result = a & b;
      ALU_OR:   result = a | b;
      ALU_PASS: result = b;
      default:  result = '0;
    endcase
    zero = (result == '0);
  end
endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile
  import lsc_pkg::*;
#(
  parameter int N = NREGS,
  parameter int W = XLEN,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b,
  input  logic [AW-1:0] ra_t,
  output logic [W-1:0]  rd_t
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign rd_t = regs[ra_t];

  AST_ZERO_REG_HELD: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == '0) |=> (regs[0] == '0)); // R2
endmodule

// File: rtl/lsc_wordmem.sv
module lsc_wordmem #(
  parameter int WORDS = 64,
  parameter int W = 32,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lsc_core.sv
module lsc_core
  import lsc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imem_we,
  input  logic [IAW-1:0]  imem_waddr,
  input  logic [31:0]     imem_wdata,
  input  logic            dmem_we,
  input  logic [DAW-1:0]  dmem_waddr,
  input  logic [31:0]     dmem_wdata,
  input  logic [RAW-1:0]  dbg_reg_sel,
  output logic [31:0]     dbg_pc,
  output logic [31:0]     dbg_reg_data
);
  logic [31:0] pc_q, pc_seq, pc_next, instr;
  logic [31:0] rs_val, rt_val, imm_ext, alu_b, alu_res, load_val, wb_val;
  logic [31:0] br_target, jmp_target;
  logic        alu_zero, take_branch, rf_we, core_dm_we;
  logic [RAW-1:0] rf_waddr;
  logic            dm_we;
  logic [DAW-1:0]  dm_waddr;
  logic [31:0]     dm_wdata;
  ctrl_t ctl;

  // fetch
  lsc_wordmem #(.WORDS(IMEM_WORDS), .W(32)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr(pc_q[IAW+1:2]), .rdata(instr)
  );

  lsc_decoder u_dec (.opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl));

  assign rf_we    = ctl.reg_write & ~rst;
  assign rf_waddr = ctl.dst_rd ? instr[15:11] : instr[20:16];

  lsc_regfile #(.N(NREGS), .W(32)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(wb_val),
    .ra_a(instr[25:21]), .rd_a(rs_val),
    .ra_b(instr[20:16]), .rd_b(rt_val),
    .ra_t(dbg_reg_sel), .rd_t(dbg_reg_data)
  );

  always_comb begin
    unique case (ctl.imm_kind)
      IMM_ZERO:  imm_ext = {16'h0000, instr[15:0]};
      IMM_UPPER: imm_ext = {instr[15:0], 16'h0000};
      default:   imm_ext = {{16{instr[15]}}, instr[15:0]};
    endcase
  end

  assign alu_b = ctl.use_imm ? imm_ext : rt_val;

  lsc_alu #(.W(32)) u_alu (
    .op(ctl.alu_op), .a(rs_val), .b(alu_b), .result(alu_res), .zero(alu_zero)
  );

  // data store: loader port wins over a core store in the same cycle
  assign core_dm_we = ctl.mem_write & ~rst;
  assign dm_we      = dmem_we | core_dm_we;
  assign dm_waddr   = dmem_we ? dmem_waddr : alu_res[DAW+1:2];
  assign dm_wdata   = dmem_we ? dmem_wdata : rt_val;

  lsc_wordmem #(.WORDS(DMEM_WORDS), .W(32)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr(alu_res[DAW+1:2]), .rdata(load_val)
  );

  assign wb_val = ctl.mem_read ? load_val : alu_res;

  // next PC
  assign pc_seq      = pc_q + 32'd4;
  assign br_target   = pc_seq + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_target  = {pc_q[31:28], instr[25:0], 2'b00};
  assign take_branch = (ctl.br_eq & alu_zero) | (ctl.br_ne & ~alu_zero);

  always_comb begin
    if (ctl.jump)          pc_next = jmp_target;
    else if (take_branch)  pc_next = br_target;
    else                   pc_next = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc = pc_q;

  AST_RESET_PC_ZERO: assert property (@(posedge clk)
    rst |=> (pc_q == '0)); // R1
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !(ctl.jump || take_branch) |=> (pc_q == $past(pc_q) + 32'd4)); // R7
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> (pc_q[31:28] == $past(pc_q[31:28]))); // R8
  AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !ctl.legal |-> (!rf_we && !core_dm_we)); // R9
endmodule

// File: tb/lsc_core_tb.sv
module lsc_core_tb;
  localparam int IMW = 64;
  localparam int DMW = 64;
  localparam int IAW = $clog2(IMW);
  localparam int DAW = $clog2(DMW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic imem_we = 1'b0, dmem_we = 1'b0;
  logic [IAW-1:0] imem_waddr = '0;
  logic [DAW-1:0] dmem_waddr = '0;
  logic [31:0] imem_wdata = '0, dmem_wdata = '0;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_pc, dbg_reg_data;

  always #2 clk = ~clk;

  lsc_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) u_dut (
    .clk(clk), .rst(rst),
    .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
    .dbg_reg_sel(dbg_reg_sel), .dbg_pc(dbg_pc), .dbg_reg_data(dbg_reg_data)
  );

  int checks = 0, errors = 0;
  logic [31:0] prog [IMW];
  logic [31:0] dinit [DMW];
  logic [31:0] m_dm [DMW];
  logic [31:0] m_rf [32];
  string       m_tag [32];
  logic [31:0] m_pc;

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input int word);
    return {6'd2, 26'(word)};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model, one instruction per call
  task automatic m_step(output string tag);
    logic [31:0] ins, a, b, sx, zx, val, nxt;
    logic [5:0] op, fn;
    int rd, rt, dst;
    logic wr;
    ins = prog[(m_pc >> 2) % IMW];
    op = ins[31:26]; fn = ins[5:0];
    rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = m_rf[ins[25:21]]; b = m_rf[rt];
    sx = {{16{ins[15]}}, ins[15:0]}; zx = {16'h0, ins[15:0]};
    nxt = m_pc + 4; wr = 1'b0; dst = rt; val = '0; tag = "R9";
    case (op)
      6'd0: begin
        dst = rd; tag = "R3";
        case (fn)
          6'd32: begin wr = 1'b1; val = a + b; end
          6'd34: begin wr = 1'b1; val = a - b; end
          6'd42: begin wr = 1'b1; val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; end
          default: tag = "R9";
        endcase
      end
      6'd8:  begin wr = 1'b1; val = a + sx; tag = "R4"; end
      6'd10: begin wr = 1'b1; val = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; tag = "R4"; end
      6'd12: begin wr = 1'b1; val = a & zx; tag = "R4"; end
      6'd13: begin wr = 1'b1; val = a | zx; tag = "R5"; end
      6'd15: begin wr = 1'b1; val = {ins[15:0], 16'h0}; tag = "R5"; end
      6'd35: begin wr = 1'b1; val = m_dm[((a + sx) >> 2) % DMW]; tag = "R6"; end
      6'd43: begin m_dm[((a + sx) >> 2) % DMW] = b; tag = "R6"; end
      6'd4:  begin tag = "R7"; if (a == b) nxt = m_pc + 4 + (sx << 2); end
      6'd5:  begin tag = "R7"; if (a != b) nxt = m_pc + 4 + (sx << 2); end
      6'd2:  begin tag = "R8"; nxt = {m_pc[31:28], ins[25:0], 2'b00}; end
      default: tag = "R9";
    endcase
    if (wr && dst != 0) begin m_rf[dst] = val; m_tag[dst] = tag; end
    m_pc = nxt;
  endtask

  // load both stores under reset, release, run in lock-step with the model
  task automatic run_prog(input int cycles);
    string ptag;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < IMW; i++) begin
      imem_we = 1'b1; imem_waddr = IAW'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    for (int i = 0; i < DMW; i++) begin
      dmem_we = 1'b1; dmem_waddr = DAW'(i); dmem_wdata = dinit[i];
      m_dm[i] = dinit[i];
      @(negedge clk);
    end
    dmem_we = 1'b0;
    for (int i = 0; i < 32; i++) begin m_rf[i] = '0; m_tag[i] = "R1"; end
    m_pc = '0;
    chk("R1", "pc in reset", dbg_pc, 32'd0);
    dbg_reg_sel = 5'(1 + ($urandom % 31));
    #1 chk("R1", "register in reset", dbg_reg_data, 32'd0);
    rst = 1'b0;
    ptag = "R1";
    for (int c = 0; c < cycles; c++) begin
      chk(ptag, "pc", dbg_pc, m_pc);
      m_step(ptag);
      @(negedge clk);
    end
    for (int r = 0; r < 32; r++) begin
      dbg_reg_sel = 5'(r);
      #0 chk((r == 0) ? "R2" : m_tag[r], $sformatf("reg %0d", r), dbg_reg_data, m_rf[r]);
    end
  endtask

  task automatic expect_reg(input string tag, input int r, input logic [31:0] exp);
    dbg_reg_sel = 5'(r);
    #1 chk(tag, $sformatf("reg %0d direct", r), dbg_reg_data, exp);
  endtask

  function automatic logic [15:0] rnd_imm();
    case ($urandom % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    // directed program
    for (int i = 0; i < IMW; i++) prog[i] = 32'h0;
    for (int i = 0; i < DMW; i++) dinit[i] = $urandom;
    dinit[1] = 32'hCAFEF00D;
    prog[0]  = enc_i(6'd15, 0, 1, 16'h1234);
    prog[1]  = enc_i(6'd13, 1, 1, 16'hABCD);
    prog[2]  = enc_i(6'd8, 0, 2, 16'hFFFF);
    prog[3]  = enc_i(6'd12, 2, 3, 16'h8001);
    prog[4]  = enc_i(6'd10, 2, 4, 16'h0000);
    prog[5]  = enc_r(6'd42, 1, 2, 5);
    prog[6]  = enc_r(6'd42, 2, 1, 6);
    prog[7]  = enc_i(6'd43, 0, 1, 16'd8);
    prog[8]  = enc_i(6'd35, 0, 7, 16'd8);
    prog[9]  = enc_i(6'd35, 0, 8, 16'd4);
    prog[10] = enc_r(6'd32, 1, 1, 0);
    prog[11] = enc_i(6'd4, 0, 0, 16'd1);
    prog[12] = enc_i(6'd8, 0, 9, 16'd7);
    prog[13] = enc_i(6'd5, 1, 1, 16'd1);
    prog[14] = enc_i(6'd8, 0, 10, 16'd5);
    prog[15] = enc_i(6'd8, 0, 11, 16'd3);
    prog[16] = enc_i(6'd8, 12, 12, 16'd1);
    prog[17] = enc_i(6'd8, 11, 11, 16'hFFFF);
    prog[18] = enc_i(6'd5, 11, 0, 16'hFFFD);
    prog[19] = enc_r(6'd34, 0, 1, 13);
    prog[20] = 32'hFFFF_FFFF;
    prog[21] = enc_r(6'd7, 1, 1, 14);
    prog[22] = enc_j(24);
    prog[23] = enc_i(6'd8, 0, 15, 16'd1);
    prog[24] = enc_j(24);
    run_prog(45);
    expect_reg("R5", 1, 32'h1234ABCD);
    expect_reg("R4", 2, 32'hFFFFFFFF);
    expect_reg("R4", 3, 32'h00008001);
    expect_reg("R4", 4, 32'd1);
    expect_reg("R3", 5, 32'd0);
    expect_reg("R3", 6, 32'd1);
    expect_reg("R6", 7, 32'h1234ABCD);
    expect_reg("R11", 8, 32'hCAFEF00D);
    expect_reg("R7", 9, 32'd0);
    expect_reg("R7", 10, 32'd5);
    expect_reg("R7", 12, 32'd3);
    expect_reg("R3", 13, 32'hEDCB5433);
    expect_reg("R9", 14, 32'd0);
    expect_reg("R8", 15, 32'd0);
    expect_reg("R10", 6, 32'd1);
    expect_reg("R10", 1, 32'h1234ABCD);
    chk("R8", "parked pc", dbg_pc, 32'd96);

    // seeded random programs
    for (int p = 0; p < 20; p++) begin
      int len;
      len = 24 + ($urandom % 16);
      for (int i = 0; i < IMW; i++) prog[i] = 32'h0;
      for (int i = 0; i < DMW; i++) dinit[i] = $urandom;
      for (int i = 0; i < len - 1; i++) begin
        int k, rs, rt, rd;
        k = $urandom % 12;
        rs = $urandom % 8; rt = $urandom % 8; rd = $urandom % 8;
        if (k == 10 && i >= len - 5) k = 3;
        case (k)
          0: prog[i] = enc_r(6'd32, rs, rt, rd);
          1: prog[i] = enc_r(6'd34, rs, rt, rd);
          2: prog[i] = enc_r(6'd42, rs, rt, rd);
          3: prog[i] = enc_i(6'd8, rs, rt, rnd_imm());
          4: prog[i] = enc_i(6'd10, rs, rt, rnd_imm());
          5: prog[i] = enc_i(6'd12, rs, rt, rnd_imm());
          6: prog[i] = enc_i(6'd13, rs, rt, rnd_imm());
          7: prog[i] = enc_i(6'd15, 0, rt, rnd_imm());
          8: prog[i] = enc_i(6'd35, 0, rt, 16'(4 * ($urandom % DMW)));
          9: prog[i] = enc_i(6'd43, 0, rt, 16'(4 * ($urandom % 4)));
          10: prog[i] = enc_i(($urandom % 2) ? 6'd4 : 6'd5, 1 + ($urandom % 3),
                              1 + ($urandom % 3), 16'($urandom % 4));
          default: prog[i] = ($urandom % 2) ? enc_r(6'($urandom % 32), rs, rt, rd)
                                            : {6'd63, 26'($urandom)};
        endcase
      end
      prog[len - 1] = enc_j(len - 1);
      run_prog(len + 10);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule